// File: doc/BRIEF.md
# Dual Doorbell Mailbox Register Bank

This block is the target-side register bank that carries command and response traffic between a host and a peer controller. It holds eight mailbox registers and two doorbell registers. The first half of the mailboxes carries the request from the host, and the second half carries the response from the peer. The host reaches every register through a single word-addressed register port. The peer has its own side ports: it reads the request half, writes the response half, and applies AND or OR masks to either doorbell.

Each doorbell answers at three neighbouring offsets. The first offset is a plain read/write. The second ANDs the written data into the register. The third ORs the written data into the register. The top bit of the peer doorbell signals that a message is waiting and drives `irq_to_peer`. The top bit of the host doorbell signals that a response is waiting and drives `irq_to_host`. If the host and the peer touch the same doorbell in the same cycle, the bank merges both updates into one result and drops no bit.

The bank has no sequencing state. Every register is a flat flop, and the next value of each register is formed in one combinational step. No state machine is present.

Top module: `mbx_bank`

## Requirements
- R1: After reset, every mailbox and doorbell register reads zero, `irq_to_peer` and `irq_to_host` are low, and `peer_req_rdata` is zero.
- R2: Mailbox i (0 to 7) sits at host offset 0x50+i. A host write takes effect at the next rising clock edge. A host read (`host_req`=1, `host_we`=0) returns the register value combinationally in the same cycle.
- R3: A host read of any offset that is not mapped returns zero. A host write to such an offset changes no register.
- R4: A doorbell at base offset B is accessed at three offsets. A write to B stores the data. A write to B+1 leaves register & data. A write to B+2 leaves register | data. A read at any of the three offsets returns the current value.
- R5: The peer doorbell has base offset 0x60 (so it answers at 0x60, 0x61 and 0x62). The host doorbell has base offset 0x63 (so it answers at 0x63, 0x64 and 0x65).
- R6: `irq_to_peer` equals bit 63 of the peer doorbell, and `irq_to_host` equals bit 63 of the host doorbell. Both follow the registered value.
- R7: `peer_req_rdata` returns request mailbox `peer_req_idx` (0 to 3) combinationally.
- R8: When `peer_rsp_we` is set, the peer writes `peer_rsp_wdata` into mailbox 4+`peer_rsp_idx`. If the host writes the same mailbox in the same cycle, the peer write wins.
- R9: When `peer_db_we` is set, the peer updates one doorbell. `peer_db_sel`=0 selects the peer doorbell and 1 selects the host doorbell. `peer_db_op`=0 ANDs the data into the register and 1 ORs it in. `peer_db_rdata` shows the doorbell that `peer_db_sel` picks.
- R10: When the host and the peer update the same doorbell in one cycle, the new value is computed in three steps. First take the base: the host plain-write data if the host does a plain write, or else the current value. Then AND the base with every AND mask present. Finally OR in every OR mask present.
- R11: A host AND with 0x7FFF_FFFF_FFFF_FFFF at offset 0x64 clears the response bit and lowers `irq_to_host`. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 8 | Host word offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, combinational |
| peer_req_idx | input | 2 | Request mailbox the peer reads |
| peer_req_rdata | output | 64 | Selected request mailbox value |
| peer_rsp_we | input | 1 | Peer writes a response mailbox |
| peer_rsp_idx | input | 2 | Response mailbox index (mailbox 4+idx) |
| peer_rsp_wdata | input | 64 | Peer response data |
| peer_db_we | input | 1 | Peer doorbell update valid |
| peer_db_sel | input | 1 | 0 = peer doorbell, 1 = host doorbell |
| peer_db_op | input | 1 | 0 = AND, 1 = OR |
| peer_db_wdata | input | 64 | Peer doorbell mask |
| peer_db_rdata | output | 64 | Value of the doorbell that `peer_db_sel` selects |
| irq_to_peer | output | 1 | Message-waiting interrupt toward the peer |
| irq_to_host | output | 1 | Response-waiting interrupt toward the host |

## Verification
The bench builds the bank with its default parameters: eight 64-bit mailboxes, an 8-bit offset, and doorbell bases at 0x60 and 0x63. With these values the interrupt bit is bit 63, and the offsets just outside each mapped window (0x4F, 0x58, 0x5F, 0x66) can be reached, so the unmapped-offset checks hit the edges of the decoder. Because the data is 64 bits wide, the exact clear mask for the response bit is used as a real stimulus. Same-cycle host and peer traffic exercises every merge case: AND against OR, plain write against OR, and a host mailbox write colliding with a peer response write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        DB_RW  = 2'd0,
        DB_AND = 2'd1,
        DB_OR  = 2'd2
    } db_op_e;

    localparam int DEF_DATA_W    = 64;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_N_MBOX    = 8;
    localparam int DEF_MBOX_BASE = 'h50;
    localparam int DEF_PDB_BASE  = 'h60;
    localparam int DEF_HDB_BASE  = 'h63;
    localparam int N_DB          = 2;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int N_MBOX    = DEF_N_MBOX,
    parameter int MBOX_BASE = DEF_MBOX_BASE,
    parameter int PDB_BASE  = DEF_PDB_BASE,
    parameter int HDB_BASE  = DEF_HDB_BASE,
    localparam int IDX_W    = $clog2(N_MBOX)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mbox_hit,
    output logic [IDX_W-1:0]  mbox_idx,
    output logic [N_DB-1:0]   db_hit,
    output db_op_e            db_op
);
    localparam logic [ADDR_W:0] MB_LO = (ADDR_W+1)'(MBOX_BASE);
    localparam logic [ADDR_W:0] MB_HI = (ADDR_W+1)'(MBOX_BASE + N_MBOX);

    logic [ADDR_W:0] a_ext;
    logic [ADDR_W:0] m_off;
    db_op_e          op_g [N_DB];

    assign a_ext    = {1'b0, addr};
    assign m_off    = a_ext - MB_LO;
    assign mbox_hit = (a_ext >= MB_LO) && (a_ext < MB_HI);
    assign mbox_idx = m_off[IDX_W-1:0];

    for (genvar g = 0; g < N_DB; g++) begin : g_db
        localparam int BASE = (g == 0) ? PDB_BASE : HDB_BASE;
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + 2);
        logic [ADDR_W:0] off;
        assign off      = a_ext - LO;
        assign db_hit[g] = (a_ext >= LO) && (a_ext <= HI);
        assign op_g[g]  = db_op_e'(off[1:0]);
    end

    always_comb begin
        db_op = DB_RW;
        for (int g = 0; g < N_DB; g++) begin
            if (db_hit[g]) db_op = op_g[g];
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_en,
    input  db_op_e            h_op,
    input  logic [DATA_W-1:0] h_data,
    input  logic              p_en,
    input  logic              p_op,
    input  logic [DATA_W-1:0] p_data,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] base_v;
    logic [DATA_W-1:0] and_m;
    logic [DATA_W-1:0] or_m;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        base_v = (h_en && h_op == DB_RW) ? h_data : q;
        and_m  = '1;
        or_m   = '0;
        if (h_en && h_op == DB_AND) and_m = and_m & h_data;
        if (h_en && h_op == DB_OR)  or_m  = or_m | h_data;
        if (p_en && !p_op)          and_m = and_m & p_data;
        if (p_en && p_op)           or_m  = or_m | p_data;
        nxt = (base_v & and_m) | or_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
    parameter int DATA_W = 64,
    parameter int N_MBOX = 8,
    localparam int IDX_W  = $clog2(N_MBOX),
    localparam int HALF   = N_MBOX / 2,
    localparam int HIDX_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_data,
    input  logic              p_we,
    input  logic [HIDX_W-1:0] p_idx,
    input  logic [DATA_W-1:0] p_data,
    output logic [DATA_W-1:0] q [N_MBOX]
);
    for (genvar i = 0; i < N_MBOX; i++) begin : g_reg
        if (i >= HALF) begin : g_rsp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= '0;
                else if (p_we && p_idx == HIDX_W'(i - HALF))
                    q[i] <= p_data;
                else if (h_we && h_idx == IDX_W'(i))
                    q[i] <= h_data;
            end
        end else begin : g_req
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[i] <= '0;
                else if (h_we && h_idx == IDX_W'(i))
                    q[i] <= h_data;
            end
        end
    end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int N_MBOX    = DEF_N_MBOX,
    parameter int MBOX_BASE = DEF_MBOX_BASE,
    parameter int PDB_BASE  = DEF_PDB_BASE,
    parameter int HDB_BASE  = DEF_HDB_BASE,
    localparam int IDX_W    = $clog2(N_MBOX),
    localparam int HIDX_W   = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [HIDX_W-1:0] peer_req_idx,
    output logic [DATA_W-1:0] peer_req_rdata,
    input  logic              peer_rsp_we,
    input  logic [HIDX_W-1:0] peer_rsp_idx,
    input  logic [DATA_W-1:0] peer_rsp_wdata,
    input  logic              peer_db_we,
    input  logic              peer_db_sel,
    input  logic              peer_db_op,
    input  logic [DATA_W-1:0] peer_db_wdata,
    output logic [DATA_W-1:0] peer_db_rdata,
    output logic              irq_to_peer,
    output logic              irq_to_host
);
    logic              mbox_hit;
    logic [IDX_W-1:0]  mbox_idx;
    logic [N_DB-1:0]   db_hit;
    db_op_e            db_op;
    logic [DATA_W-1:0] mbox_q [N_MBOX];
    logic [DATA_W-1:0] db_q   [N_DB];
    logic              host_wr;

    assign host_wr = host_req && host_we;

    mbx_decode #(
        .ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .MBOX_BASE(MBOX_BASE),
        .PDB_BASE(PDB_BASE), .HDB_BASE(HDB_BASE)
    ) u_dec (
        .addr(host_addr), .mbox_hit(mbox_hit), .mbox_idx(mbox_idx),
        .db_hit(db_hit), .db_op(db_op)
    );

    mbx_regfile #(.DATA_W(DATA_W), .N_MBOX(N_MBOX)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_wr && mbox_hit), .h_idx(mbox_idx), .h_data(host_wdata),
        .p_we(peer_rsp_we), .p_idx(peer_rsp_idx), .p_data(peer_rsp_wdata),
        .q(mbox_q)
    );

    for (genvar g = 0; g < N_DB; g++) begin : g_db
        mbx_doorbell #(.DATA_W(DATA_W)) u_db (
            .clk(clk), .rst_n(rst_n),
            .h_en(host_wr && db_hit[g]), .h_op(db_op), .h_data(host_wdata),
            .p_en(peer_db_we && (peer_db_sel == 1'(g))),
            .p_op(peer_db_op), .p_data(peer_db_wdata),
            .q(db_q[g])
        );
    end

    always_comb begin
        host_rdata = '0;
        if (host_req && !host_we) begin
            if (mbox_hit)       host_rdata = mbox_q[mbox_idx];
            else if (db_hit[0]) host_rdata = db_q[0];
            else if (db_hit[1]) host_rdata = db_q[1];
        end
    end

    assign peer_req_rdata = mbox_q[IDX_W'(peer_req_idx)];
    assign peer_db_rdata  = peer_db_sel ? db_q[1] : db_q[0];
    assign irq_to_peer    = db_q[0][DATA_W-1];
    assign irq_to_host    = db_q[1][DATA_W-1];
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 8,
    parameter int N_MBOX    = 8,
    parameter int MBOX_BASE = 'h50,
    parameter int PDB_BASE  = 'h60,
    parameter int HDB_BASE  = 'h63,
    localparam int IDX_W    = $clog2(N_MBOX),
    localparam int HIDX_W   = IDX_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [HIDX_W-1:0] peer_req_idx,
    input logic [DATA_W-1:0] peer_req_rdata,
    input logic              peer_rsp_we,
    input logic [HIDX_W-1:0] peer_rsp_idx,
    input logic [DATA_W-1:0] peer_rsp_wdata,
    input logic              peer_db_we,
    input logic              peer_db_sel,
    input logic              peer_db_op,
    input logic [DATA_W-1:0] peer_db_wdata,
    input logic [DATA_W-1:0] peer_db_rdata,
    input logic              irq_to_peer,
    input logic              irq_to_host
);
    logic [ADDR_W:0] a;
    logic            in_mbox, in_req, in_pdb, in_hdb, mapped;
    logic            wr_pdb, wr_hdb, wr_req;

    assign a       = {1'b0, host_addr};
    assign in_mbox = a >= (ADDR_W+1)'(MBOX_BASE) && a < (ADDR_W+1)'(MBOX_BASE + N_MBOX);
    assign in_req  = a >= (ADDR_W+1)'(MBOX_BASE) && a < (ADDR_W+1)'(MBOX_BASE + N_MBOX/2);
    assign in_pdb  = a >= (ADDR_W+1)'(PDB_BASE) && a <= (ADDR_W+1)'(PDB_BASE + 2);
    assign in_hdb  = a >= (ADDR_W+1)'(HDB_BASE) && a <= (ADDR_W+1)'(HDB_BASE + 2);
    assign mapped  = in_mbox || in_pdb || in_hdb;
    assign wr_pdb  = (host_req && host_we && in_pdb) || (peer_db_we && !peer_db_sel);
    assign wr_hdb  = (host_req && host_we && in_hdb) || (peer_db_we && peer_db_sel);
    assign wr_req  = host_req && host_we && in_req;

    // R3: unmapped reads return zero
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && !mapped) |-> host_rdata == '0);

    // R6: the peer interrupt rises only after a doorbell update
    p_irq_peer_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_to_peer) |-> $past(wr_pdb));

    // R11: the host interrupt falls only after a doorbell update
    p_irq_host_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_to_host) |-> $past(wr_hdb));

    // R7: request view holds while nothing writes the request half
    p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(peer_req_idx) && !$past(wr_req)) |-> $stable(peer_req_rdata));

    // R10: a peer OR of the top bit always wins over any AND
    p_or_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_db_we && !peer_db_sel && peer_db_op && peer_db_wdata[DATA_W-1]) |=> irq_to_peer);

    // R9: peer OR of the response bit raises the host interrupt
    p_peer_or_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_db_we && peer_db_sel && peer_db_op && peer_db_wdata[DATA_W-1]) |=> irq_to_host);
endmodule

bind mbx_bank mbx_bank_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_MBOX(N_MBOX),
    .MBOX_BASE(MBOX_BASE), .PDB_BASE(PDB_BASE), .HDB_BASE(HDB_BASE)
) u_chk (.*);

// File: tb/mbx_bank_tb.sv
module mbx_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [63:0] host_wdata = '0, host_rdata;
    logic [1:0]  peer_req_idx = '0;
    logic [63:0] peer_req_rdata;
    logic        peer_rsp_we = 1'b0;
    logic [1:0]  peer_rsp_idx = '0;
    logic [63:0] peer_rsp_wdata = '0;
    logic        peer_db_we = 1'b0, peer_db_sel = 1'b0, peer_db_op = 1'b0;
    logic [63:0] peer_db_wdata = '0, peer_db_rdata;
    logic        irq_to_peer, irq_to_host;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbx_bank u_dut (.*);

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h50, 64'hA5A5_5A5A_0F0F_F0F0},  // R2 write mailbox 0
        '{1'b1, 8'h57, 64'h0123_4567_89AB_CDEF},  // R2 write mailbox 7
        '{1'b0, 8'h50, 64'hA5A5_5A5A_0F0F_F0F0},  // R2 read back
        '{1'b0, 8'h57, 64'h0123_4567_89AB_CDEF},  // R2 read back
        '{1'b1, 8'h60, 64'h0000_0000_0000_00F0},  // R4 R5 plain write
        '{1'b1, 8'h62, 64'h0000_0000_0000_000F},  // R4 OR alias -> FF
        '{1'b1, 8'h61, 64'hFFFF_FFFF_FFFF_FF3C},  // R4 AND alias -> 3C
        '{1'b0, 8'h60, 64'h0000_0000_0000_003C},  // R4 read plain
        '{1'b0, 8'h61, 64'h0000_0000_0000_003C},  // R4 read AND alias
        '{1'b0, 8'h62, 64'h0000_0000_0000_003C},  // R4 read OR alias
        '{1'b1, 8'h65, 64'h8000_0000_0000_0001},  // R5 host doorbell OR
        '{1'b0, 8'h63, 64'h8000_0000_0000_0001},  // R5 read
        '{1'b1, 8'h64, 64'h7FFF_FFFF_FFFF_FFFF},  // R11 clear response bit
        '{1'b0, 8'h65, 64'h0000_0000_0000_0001}   // R11 other bits kept
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        #1;
        chk(host_rdata === exp, tag, host_rdata, exp);
        host_req = 1'b0;
    endtask

    task automatic peer_db(input logic sel, input logic op, input logic [63:0] d);
        @(negedge clk);
        peer_db_we = 1'b1; peer_db_sel = sel; peer_db_op = op; peer_db_wdata = d;
        @(negedge clk);
        peer_db_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        hread(8'h50, 64'h0, "R1 mailbox0");
        hread(8'h57, 64'h0, "R1 mailbox7");
        hread(8'h60, 64'h0, "R1 peer doorbell");
        hread(8'h63, 64'h0, "R1 host doorbell");
        chk(!irq_to_peer && !irq_to_host, "R1 irqs", {62'h0, irq_to_peer, irq_to_host}, 64'h0);
        chk(peer_req_rdata === 64'h0, "R1 peer_req_rdata", peer_req_rdata, 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) hwrite(VEC[i].addr, VEC[i].data);
            else           hread(VEC[i].addr, VEC[i].data, "R2/R4/R5/R11 vector");
        end
        chk(!irq_to_host, "R11 irq_to_host low", {63'h0, irq_to_host}, 64'h0);

        // R6: message bit drives peer interrupt
        hwrite(8'h62, 64'h8000_0000_0000_0000);
        chk(irq_to_peer, "R6 irq_to_peer set", {63'h0, irq_to_peer}, 64'h1);
        hwrite(8'h61, 64'h7FFF_FFFF_FFFF_FFFF);
        chk(!irq_to_peer, "R6 irq_to_peer clear", {63'h0, irq_to_peer}, 64'h0);

        // R9: peer raises response bit on host doorbell
        peer_db(1'b1, 1'b1, 64'h8000_0000_0000_0000);
        chk(irq_to_host, "R9 irq_to_host set", {63'h0, irq_to_host}, 64'h1);
        hwrite(8'h64, 64'h7FFF_FFFF_FFFF_FFFF);
        chk(!irq_to_host, "R11 clear again", {63'h0, irq_to_host}, 64'h0);
        hread(8'h63, 64'h1, "R11 low bit kept");

        // R3: unmapped offsets
        hwrite(8'h58, 64'hDEAD);
        hwrite(8'h4F, 64'hBEEF);
        hwrite(8'h5F, 64'hCAFE);
        hwrite(8'h66, 64'hF00D);
        hread(8'h58, 64'h0, "R3 read 0x58");
        hread(8'h4F, 64'h0, "R3 read 0x4F");
        hread(8'h66, 64'h0, "R3 read 0x66");
        hread(8'h50, 64'hA5A5_5A5A_0F0F_F0F0, "R3 mailbox0 kept");
        hread(8'h51, 64'h0, "R3 mailbox1 kept");
        hread(8'h57, 64'h0123_4567_89AB_CDEF, "R3 mailbox7 kept");
        hread(8'h60, 64'h3C, "R3 peer doorbell kept");
        hread(8'h63, 64'h1, "R3 host doorbell kept");

        // R7: peer reads request mailbox
        hwrite(8'h52, 64'h1111_2222_3333_4444);
        @(negedge clk);
        peer_req_idx = 2'd2;
        #1;
        chk(peer_req_rdata === 64'h1111_2222_3333_4444, "R7 peer read idx2", peer_req_rdata, 64'h1111_2222_3333_4444);

        // R8: peer response write and collision
        @(negedge clk);
        peer_rsp_we = 1'b1; peer_rsp_idx = 2'd1; peer_rsp_wdata = 64'h5555;
        @(negedge clk);
        peer_rsp_we = 1'b0;
        hread(8'h55, 64'h5555, "R8 peer write mailbox5");
        @(negedge clk);
        peer_rsp_we = 1'b1; peer_rsp_idx = 2'd2; peer_rsp_wdata = 64'h6666;
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h56; host_wdata = 64'h7777;
        @(negedge clk);
        peer_rsp_we = 1'b0; host_req = 1'b0; host_we = 1'b0;
        hread(8'h56, 64'h6666, "R8 peer wins collision");

        // R9: peer AND on peer doorbell, side read
        peer_db(1'b0, 1'b0, 64'h0C);
        @(negedge clk);
        peer_db_sel = 1'b0;
        #1;
        chk(peer_db_rdata === 64'h0C, "R9 peer AND", peer_db_rdata, 64'h0C);

        // R10: host OR + peer AND same cycle
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h62; host_wdata = 64'h30;
        peer_db_we = 1'b1; peer_db_sel = 1'b0; peer_db_op = 1'b0; peer_db_wdata = 64'h04;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; peer_db_we = 1'b0;
        hread(8'h60, 64'h34, "R10 OR with AND");

        // R10: host plain write + peer OR
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h60; host_wdata = 64'hFF00;
        peer_db_we = 1'b1; peer_db_sel = 1'b0; peer_db_op = 1'b1; peer_db_wdata = 64'h01;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; peer_db_we = 1'b0;
        hread(8'h61, 64'hFF01, "R10 plain with OR");

        // R10: host AND zero + peer OR top bit on host doorbell
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h64; host_wdata = 64'h0;
        peer_db_we = 1'b1; peer_db_sel = 1'b1; peer_db_op = 1'b1; peer_db_wdata = 64'h8000_0000_0000_0000;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; peer_db_we = 1'b0;
        hread(8'h63, 64'h8000_0000_0000_0000, "R10 AND with OR host doorbell");
        chk(irq_to_host, "R10 irq_to_host after merge", {63'h0, irq_to_host}, 64'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule